// File: doc/BRIEF.md
# Dual Wiper I2C Register Slave

This block is the serial control front end of a two-channel digital potentiometer. It oversamples the I2C clock and data lines with a fast system clock. Both lines pass through a synchroniser and a glitch filter. The block then detects START, repeated START and STOP conditions and moves bytes in and out of a small register set. Two 7-bit wiper codes and one control register are held there. The wiper codes and a shutdown flag leave the block as registered outputs that drive the analog section. The open-drain data driver is modelled as a pull-low enable, `sda_pull_o`. The board resolves the bus level as the master's level ANDed with the inverse of that enable.

A host selects the device with an identification byte. Three strap inputs set part of that byte, so up to eight of these slaves can share one bus. The host then sends a register address. In a write, one or more data bytes follow. In a read, a repeated START and a read identification byte follow, and the slave returns data until the host answers with a NACK. Consecutive data bytes walk across the wiper channels, so both wipers can be set or read in a single transaction.

Top module: `dpot_i2c_regs`

## Requirements
- R1: After reset, both wiper codes are 40h and `shutdown_o` is 0. The control register reads back as 40h.
- R2: The slave acknowledges an identification byte only when its seven upper bits equal 1010 followed by `strap_i[2:0]`. Bit 0 is the direction: 1 means read, 0 means write. With any other identification byte the slave keeps SDA released until the next START, and no register changes.
- R3: Writing a data byte to address 00h or 01h loads its bits 6:0 into wiper 0 or wiper 1 respectively. Bit 7 is discarded, and it reads back as 0.
- R4: A written value appears on the outputs only after the rising SCL edge of the ninth (acknowledge) clock of its data byte. It does not appear after the eighth data bit.
- R5: When further data bytes follow without a STOP, the register address advances from 00h to 01h and then wraps back to 00h. At address 10h the address does not move, so the last byte written there wins.
- R6: Address 10h is the control register. Bit 6 written as 0 sets `shutdown_o` to 1, and written as 1 clears it. On read, bit 6 returns the inverse of `shutdown_o` and every other bit returns 0.
- R7: An address byte other than 00h, 01h or 10h is not acknowledged. Data bytes that follow it in the same transaction change nothing.
- R8: A read returns the register at the current address, MSB first, after a repeated START. While the host acknowledges, the address advances as in R5 and the next register is sent. A host NACK ends the data phase.
- R9: A STOP returns the slave to idle. Bytes clocked without a preceding START are not acknowledged and change nothing.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks (4 clocks, 80 ns, by default) is rejected. It neither adds a bit nor forms a START or STOP.
- R11: The slave changes `sda_pull_o` only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock level from the bus |
| sda_i | input | 1 | Raw serial data level from the bus |
| strap_i | input | 3 | Board strap levels forming identification bits 3:1 |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| wiper0_o | output | 7 | Tap code of channel 0 |
| wiper1_o | output | 7 | Tap code of channel 1 |
| shutdown_o | output | 1 | 1 when the control register selects shutdown |

## Verification
Several properties are checked on every cycle. The data-line enable never moves while the filtered clock is high. It stays released while the slave is idle or ignoring a transaction. Wiper codes and the shutdown flag change only two cycles after a filtered clock rise, that is, on an acknowledge clock. The reset values hold as reset is released. The rest can only be shown by the bench's bus scenarios:
- that the value landing in a register is the right one, and that bit 7 is masked;
- the address walk and its wrap;
- rejection of a wrong identification byte or an unmapped address;
- readback through repeated START;
- rejection of narrow glitches on either line.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ID_PREFIX = 4'b1010;
  localparam logic [BYTE_W-1:0] ADDR_CTRL = 8'h10;
  localparam logic [BYTE_W-1:0] RESET_VAL = 8'h40;
  localparam int SHDN_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGN
  } xfer_st_t;

  typedef enum logic [1:0] {
    BK_ID, BK_ADDR, BK_DATA
  } byte_kind_t;

  function automatic logic addr_valid(input logic [BYTE_W-1:0] a);
    return (a < BYTE_W'(NUM_CH)) || (a == ADDR_CTRL);
  endfunction

  function automatic logic [BYTE_W-1:0] next_addr(input logic [BYTE_W-1:0] a);
    if (a < BYTE_W'(NUM_CH - 1)) return a + 8'd1;
    else if (a == BYTE_W'(NUM_CH - 1)) return 8'd0;
    else return a;
  endfunction
endpackage

// File: rtl/dpot_deglitch.sv
module dpot_deglitch #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // Output follows the synchronised level only after it has differed
  // for STABLE_CYC consecutive clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dpot_bus_events.sv
module dpot_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CODE_W-1:0] wiper_o [NUM_CH],
  output logic              shut_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= RESET_VAL[CODE_W-1:0];
      else if (wr_en && wr_addr == BYTE_W'(ch)) code_q <= wr_code;
    end
    assign wiper_o[ch] = code_q;
  end

  // Control bit is stored already inverted as the shutdown flag.
  always_ff @(posedge clk) begin
    if (rst) shut_o <= ~RESET_VAL[SHDN_BIT];
    else if (wr_en && wr_addr == ADDR_CTRL) shut_o <= ~wr_code[SHDN_BIT];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) rd_data[SHDN_BIT] = ~shut_o;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (rd_addr == BYTE_W'(ch)) rd_data = BYTE_W'(wiper_o[ch]);
    end
  end
endmodule

// File: rtl/dpot_xfer_fsm.sv
module dpot_xfer_fsm
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_f,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              pull_o,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [CODE_W-1:0] wr_code,
  output logic [BYTE_W-1:0] ptr_o,
  output xfer_st_t          state_o
);
  xfer_st_t          state;
  byte_kind_t        kind;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, txsh, ptr;
  logic              rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= BK_ID;
      cnt     <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      pull_o  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_code <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev) begin
        state  <= ST_IDLE;
        pull_o <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_RX;
        kind   <= BK_ID;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_f};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              unique case (kind)
                BK_ID: begin
                  if (shreg[7:1] == {ID_PREFIX, strap_i}) begin
                    pull_o  <= 1'b1;
                    rd_mode <= shreg[0];
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IGN;
                  end
                end
                BK_ADDR: begin
                  if (addr_valid(shreg)) begin
                    pull_o <= 1'b1;
                    ptr    <= shreg;
                    state  <= ST_ACK;
                  end else begin
                    state <= ST_IGN;
                  end
                end
                default: begin
                  pull_o  <= 1'b1;
                  wr_code <= shreg[CODE_W-1:0];
                  state   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_rise && kind == BK_DATA) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              ptr     <= next_addr(ptr);
            end else if (scl_fall) begin
              if (kind == BK_ID && rd_mode) begin
                state  <= ST_TX;
                txsh   <= {rd_data[BYTE_W-2:0], 1'b0};
                pull_o <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
              end else begin
                pull_o <= 1'b0;
                state  <= ST_RX;
                kind   <= (kind == BK_ID) ? BK_ADDR : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                pull_o <= 1'b0;
                state  <= ST_MACK;
              end else begin
                pull_o <= ~txsh[BYTE_W-1];
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_f) ptr <= next_addr(ptr);
              else state <= ST_IGN;
            end else if (scl_fall) begin
              state  <= ST_TX;
              txsh   <= {rd_data[BYTE_W-2:0], 1'b0};
              pull_o <= ~rd_data[BYTE_W-1];
              cnt    <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o   = ptr;
  assign state_o = state;
endmodule

// File: rtl/dpot_i2c_regs.sv
module dpot_i2c_regs
  import dpot_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int CODE_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_pull_o,
  output logic [CODE_W-1:0] wiper0_o,
  output logic [CODE_W-1:0] wiper1_o,
  output logic              shutdown_o
);
  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [BYTE_W-1:0] wr_addr, ptr, rd_data;
  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] wipers [NUM_CH];
  xfer_st_t fsm_state;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    dpot_deglitch #(.STABLE_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst(rst), .line_i(raw_lines[g]), .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  dpot_bus_events u_events (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  dpot_xfer_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_f(sda_f),
    .strap_i(strap_i), .rd_data(rd_data), .pull_o(sda_pull_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .ptr_o(ptr), .state_o(fsm_state)
  );

  dpot_regfile #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_code(wr_code), .rd_addr(ptr), .rd_data(rd_data),
    .wiper_o(wipers), .shut_o(shutdown_o)
  );

  assign wiper0_o = wipers[0];
  assign wiper1_o = wipers[1];
endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_f,
  input logic              scl_rise,
  input logic              sda_pull_o,
  input logic [CODE_W-1:0] wiper0_o,
  input logic [CODE_W-1:0] wiper1_o,
  input logic              shutdown_o,
  input xfer_st_t          fsm_state
);
  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wiper0_o == CODE_W'(8'h40) && wiper1_o == CODE_W'(8'h40) && !shutdown_o));

  // R11
  pull_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

  // R2
  ignore_released_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IGN) |-> !sda_pull_o);

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE) |-> !sda_pull_o);

  // R4
  wiper0_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper0_o) |-> $past(scl_rise, 2));

  // R4
  wiper1_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper1_o) |-> $past(scl_rise, 2));

  // R6
  shutdown_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(shutdown_o) |-> $past(scl_rise, 2));
endmodule

bind dpot_i2c_regs dpot_i2c_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .scl_rise(scl_rise),
  .sda_pull_o(sda_pull_o), .wiper0_o(wiper0_o), .wiper1_o(wiper1_o),
  .shutdown_o(shutdown_o), .fsm_state(fsm_state)
);

// File: tb/test_dpot_i2c_regs.sv
module test_dpot_i2c_regs;
  localparam int QP = 10;
  localparam logic [2:0] STRAP = 3'b101;
  // {address, written byte, expected readback}
  localparam logic [23:0] VEC [8] = '{
    24'h00_7F_7F, 24'h00_FF_7F, 24'h00_00_00, 24'h01_A5_25,
    24'h01_40_40, 24'h10_00_00, 24'h10_FF_40, 24'h10_BF_00
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, shutdown;
  logic [6:0] wiper0, wiper1;
  logic sda_line;
  int n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_pull;
  always #10 clk = ~clk;

  dpot_i2c_regs i_dpot_i2c_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .sda_pull_o(sda_pull), .wiper0_o(wiper0), .wiper1_o(wiper1),
    .shutdown_o(shutdown)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QP) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  // glitch: 2-cycle low pulse on SDA during the high phase of every 1 bit
  task automatic bits8(input logic [7:0] v, input logic glitch);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; q(); scl_m = 1'b1; q();
      if (glitch && v[i]) begin
        sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
      end
      q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic ack_clk(output logic acked);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); acked = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    bits8(v, 1'b0);
    ack_clk(acked);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); v[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = mack ? 1'b0 : 1'b1;
    q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_id(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic write1(input logic [7:0] addr, input logic [7:0] data);
    logic a;
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(addr, a); wr_byte(data, a); stop_c();
  endtask

  task automatic read1(input logic [7:0] addr, output logic [7:0] v);
    logic a;
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(addr, a);
    start_c(); wr_byte(dev_id(1'b1), a); rd_byte(1'b0, v); stop_c();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    q();
    // R1 reset state
    check("R1 wiper0 reset", {1'b0, wiper0}, 8'h40);
    check("R1 wiper1 reset", {1'b0, wiper1}, 8'h40);
    check("R1 shutdown reset", {7'b0, shutdown}, 8'h00);
    read1(8'h10, v);
    check("R1 control readback", v, 8'h40);

    // R3 R6 table: write, read back, check port
    for (int k = 0; k < 8; k++) begin
      write1(VEC[k][23:16], VEC[k][15:8]);
      read1(VEC[k][23:16], v);
      check("R3/R6 readback", v, VEC[k][7:0]);
      if (VEC[k][23:16] == 8'h00) check("R3 wiper0 port", {1'b0, wiper0}, VEC[k][7:0]);
      else if (VEC[k][23:16] == 8'h01) check("R3 wiper1 port", {1'b0, wiper1}, VEC[k][7:0]);
      else check("R6 shutdown port", {7'b0, shutdown}, {7'b0, ~VEC[k][6]});
    end

    // R2 wrong strap bits and wrong prefix
    start_c(); wr_byte({4'b1010, 3'b100, 1'b0}, a);
    check("R2 strap mismatch ack", {7'b0, a}, 8'h00);
    wr_byte(8'h00, a); wr_byte(8'h55, a); stop_c();
    check("R2 wiper0 untouched", {1'b0, wiper0}, 8'h00);
    start_c(); wr_byte({4'b1011, STRAP, 1'b0}, a);
    check("R2 prefix mismatch ack", {7'b0, a}, 8'h00);
    stop_c();

    // R4 commit only on the ninth clock
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h00, a);
    bits8(8'h2A, 1'b0);
    check("R4 before ack clock", {1'b0, wiper0}, 8'h00);
    ack_clk(a);
    check("R4 after ack clock", {1'b0, wiper0}, 8'h2A);
    stop_c();

    // R5 sequential walk with wrap
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h00, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a); stop_c();
    check("R5 wiper0 after wrap", {1'b0, wiper0}, 8'h33);
    check("R5 wiper1 sequential", {1'b0, wiper1}, 8'h22);
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h10, a);
    wr_byte(8'h00, a); wr_byte(8'h40, a); stop_c();
    check("R5 control last wins", {7'b0, shutdown}, 8'h00);
    check("R5 wiper0 not walked into", {1'b0, wiper0}, 8'h33);

    // R7 unmapped addresses
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h02, a);
    check("R7 addr 02 nack", {7'b0, a}, 8'h00);
    wr_byte(8'h05, a); stop_c();
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h11, a);
    check("R7 addr 11 nack", {7'b0, a}, 8'h00);
    wr_byte(8'h05, a); stop_c();
    check("R7 wiper0 unchanged", {1'b0, wiper0}, 8'h33);
    check("R7 wiper1 unchanged", {1'b0, wiper1}, 8'h22);

    // R8 burst read with wrap
    start_c(); wr_byte(dev_id(1'b0), a); wr_byte(8'h01, a);
    start_c(); wr_byte(dev_id(1'b1), a);
    check("R8 read id ack", {7'b0, a}, 8'h01);
    rd_byte(1'b1, v); check("R8 first byte", v, 8'h22);
    rd_byte(1'b1, v); check("R8 second byte wraps", v, 8'h33);
    rd_byte(1'b0, v); check("R8 third byte", v, 8'h22);
    stop_c();

    // R9 bytes without START
    bits8(dev_id(1'b0), 1'b0); ack_clk(a);
    check("R9 no start no ack", {7'b0, a}, 8'h00);
    bits8(8'h00, 1'b0); ack_clk(a); bits8(8'h66, 1'b0); ack_clk(a);
    stop_c();
    check("R9 wiper0 unchanged", {1'b0, wiper0}, 8'h33);

    // R10 SCL glitch while low, SDA glitches while high
    start_c(); wr_byte(dev_id(1'b0), a);
    scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0; q();
    wr_byte(8'h01, a);
    check("R10 addr acked after SCL glitch", {7'b0, a}, 8'h01);
    bits8(8'h7F, 1'b1); ack_clk(a); stop_c();
    check("R10 wiper1 after SDA glitches", {1'b0, wiper1}, 8'h7F);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; q();
    check("R1 wiper0 re-reset", {1'b0, wiper0}, 8'h40);
    check("R1 wiper1 re-reset", {1'b0, wiper1}, 8'h40);

    finish_run();
  end
endmodule